// File: doc/BRIEF.md
# LPC Cycle Start and Type Decoder

This block sits at the front of a low-pin-count bus target. On every rising clock edge it samples the active-low frame strobe and the 4-bit multiplexed bus nibble. While the strobe is low, it keeps the most recent nibble as the START code. On the first edge where the strobe is seen high again, it classifies the cycle. The possible results are a generic memory cycle, whose direction comes from the nibble on that same edge, a firmware read, or a firmware write.

A recognised cycle produces a one-clock accept pulse. The pulse comes with a cycle kind and a write flag, all valid in the same clock, and goes to the downstream address and data engine. Unknown START codes and non-memory cycle types are dropped without any response, and the block never drives the bus. The block also flags an abort when the strobe falls while the downstream engine reports it is busy. It raises a standby indication when the bus is quiet and nothing is in progress.

Top module: `lpc_cycle_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output (`accept_o`, `kind_o`, `wr_o`, `abort_o`, `standby_o`) is 0 after that edge.
- R2: The START code is the nibble sampled on the last edge with `frame_n` low. When `frame_n` stays low for several edges, each edge overwrites the code, so only the final nibble decides the cycle.
- R3: START 4'b0000 is a generic memory cycle. On the first edge with `frame_n` high, if nibble bits [3:2] are 2'b01, the cycle is accepted with `kind_o` = 2'b01 and `wr_o` = nibble bit 1 (0 read, 1 write).
- R4: START 4'b1101 is accepted as a firmware read (`kind_o` = 2'b10, `wr_o` = 0). START 4'b1110 is accepted as a firmware write (`kind_o` = 2'b11, `wr_o` = 1). For both, the nibble that follows has no effect.
- R5: Any START code other than 4'b0000, 4'b1101 and 4'b1110 produces no accept. The block returns to idle.
- R6: `accept_o` is high for exactly one clock: the clock after the first edge that samples `frame_n` high following a low phase. It is never high earlier.
- R7: After START 4'b0000, a type nibble whose bits [3:2] are not 2'b01 produces no accept.
- R8: If `frame_n` is low on the edge where the type nibble was expected, the pending cycle is abandoned and START capture continues. The cycle that is finally decoded uses the new START code.
- R9: `abort_o` is high for the one clock following each edge that samples `frame_n` low while `busy_in` is high, and low otherwise.
- R10: `standby_o` is high in the clock after an edge that samples `frame_n` high and `busy_in` low, with no frame being decoded at that edge. Otherwise it is low.
- R11: Whenever `accept_o` is low, `kind_o` is 2'b00 and `wr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame strobe from the host, active low |
| lad_in | input | 4 | Sampled multiplexed bus nibble |
| busy_in | input | 1 | Downstream engine has a cycle in progress |
| accept_o | output | 1 | One-clock pulse: a cycle was recognised |
| kind_o | output | 2 | 00 none, 01 generic memory, 10 firmware read, 11 firmware write |
| wr_o | output | 1 | 1 for a write cycle, 0 for a read |
| abort_o | output | 1 | Strobe fell while downstream was busy |
| standby_o | output | 1 | Bus idle and nothing in progress |

## Verification
The assertions assume that inputs change only away from the rising edge and are known once reset is released. They also assume that `busy_in` is a level the bench controls directly, not a value derived from `accept_o`. The stimulus drives every input on the falling edge, holds `busy_in` low except in the abort and standby scenario, and follows each cycle with at least one idle clock. This keeps the one-clock accept window that the pulse-width property relies on.

// File: rtl/lpcd_pkg.sv
package lpcd_pkg;

  localparam int NIB_W  = 4;
  localparam int KIND_W = 2;

  localparam logic [NIB_W-1:0] START_GEN_MEM = 4'b0000;
  localparam logic [NIB_W-1:0] START_FW_RD   = 4'b1101;
  localparam logic [NIB_W-1:0] START_FW_WR   = 4'b1110;
  localparam logic [1:0]       TYPE_MEMORY   = 2'b01;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE    = 2'b00,
    KIND_GEN_MEM = 2'b01,
    KIND_FW_RD   = 2'b10,
    KIND_FW_WR   = 2'b11
  } cyc_kind_e;

  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_FRAME = 1'b1
  } frame_state_e;

  typedef struct packed {
    logic      hit;
    cyc_kind_e kind;
    logic      wr;
  } decode_t;

  // START code is legal when it names one of the three supported cycles.
  function automatic logic start_is_legal(input logic [NIB_W-1:0] code);
    return (code == START_GEN_MEM) || (code == START_FW_RD) || (code == START_FW_WR);
  endfunction

  // Classification of a START code together with the nibble after it.
  function automatic decode_t classify(input logic [NIB_W-1:0] code,
                                       input logic [NIB_W-1:0] nxt);
    decode_t d;
    d.hit  = 1'b0;
    d.kind = KIND_NONE;
    d.wr   = 1'b0;
    case (code)
      START_GEN_MEM: begin
        if (nxt[3:2] == TYPE_MEMORY) begin
          d.hit  = 1'b1;
          d.kind = KIND_GEN_MEM;
          d.wr   = nxt[1];
        end
      end
      START_FW_RD: begin
        d.hit  = 1'b1;
        d.kind = KIND_FW_RD;
        d.wr   = 1'b0;
      end
      START_FW_WR: begin
        d.hit  = 1'b1;
        d.kind = KIND_FW_WR;
        d.wr   = 1'b1;
      end
      default: d = d;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lpcd_frame_track.sv
module lpcd_frame_track
  import lpcd_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_n,
  input  logic [W-1:0] lad_in,
  output logic [W-1:0] start_q,
  output logic         in_frame,
  output logic         start_done
);

  frame_state_e state_q, state_d;

  always_comb begin
    state_d = frame_n ? FS_IDLE : FS_FRAME;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      start_q <= '0;
    end else begin
      state_q <= state_d;
      if (!frame_n) begin
        start_q <= lad_in;
      end
    end
  end

  assign in_frame   = (state_q == FS_FRAME);
  assign start_done = in_frame && frame_n;

  // R2: every low-strobe edge overwrites the captured START code
  p_start_overwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> start_q == $past(lad_in));

  // R2: a frame is only finished on a high edge after a low one
  p_done_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> $past(!frame_n));

endmodule

// File: rtl/lpcd_classifier.sv
module lpcd_classifier
  import lpcd_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic [W-1:0] start_q,
  input  logic [W-1:0] lad_in,
  input  logic         start_done,
  output decode_t      dec,
  output logic         legal_start
);

  decode_t raw;

  always_comb begin
    raw         = classify(start_q, lad_in);
    legal_start = start_is_legal(start_q);
    dec         = raw;
    if (!start_done) begin
      dec.hit  = 1'b0;
      dec.kind = KIND_NONE;
      dec.wr   = 1'b0;
    end
  end

  // R5: a hit is never reported for an unknown START code
  always_comb begin
    if (dec.hit) begin
      p_hit_legal_r5: assert (legal_start);
    end
  end

endmodule

// File: rtl/lpcd_out_stage.sv
module lpcd_out_stage
  import lpcd_pkg::*;
#(
  parameter int W = NIB_W,
  parameter int K = KIND_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  decode_t      dec,
  input  logic         in_frame,
  input  logic         frame_n,
  input  logic [W-1:0] lad_in,
  input  logic         busy_in,
  output logic         accept_o,
  output logic [K-1:0] kind_o,
  output logic         wr_o,
  output logic         abort_o,
  output logic         standby_o
);

  logic      accept_q, wr_q, abort_q, standby_q;
  cyc_kind_e kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_q  <= 1'b0;
      kind_q    <= KIND_NONE;
      wr_q      <= 1'b0;
      abort_q   <= 1'b0;
      standby_q <= 1'b0;
    end else begin
      accept_q  <= dec.hit;
      kind_q    <= dec.hit ? dec.kind : KIND_NONE;
      wr_q      <= dec.hit && dec.wr;
      abort_q   <= !frame_n && busy_in;
      standby_q <= frame_n && !busy_in && !in_frame;
    end
  end

  assign accept_o  = accept_q;
  assign kind_o    = kind_q;
  assign wr_o      = wr_q;
  assign abort_o   = abort_q;
  assign standby_o = standby_q;

  // R3: generic memory accept carries the type nibble's direction
  p_gen_mem_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && kind_o == KIND_GEN_MEM) |->
      ($past(lad_in[3:2]) == TYPE_MEMORY) && (wr_o == $past(lad_in[1])));

  // R4: firmware kinds have a direction fixed by the kind
  p_fw_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && kind_o[1]) |-> (wr_o == kind_o[0]));

  // R6: accept never lasts two clocks
  p_accept_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o);

  // R9: strobe falling while busy raises abort on the next clock
  p_abort_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && busy_in) |=> abort_o);

  // R9: abort only after a low strobe
  p_abort_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(!frame_n));

  // R10: standby only after a quiet, non-busy edge
  p_standby_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> ($past(frame_n) && !$past(busy_in)));

  // R11: kind and direction are zero outside the accept pulse
  p_quiet_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_o |-> (kind_o == KIND_NONE && !wr_o));

endmodule

// File: rtl/lpc_cycle_decoder.sv
module lpc_cycle_decoder
  import lpcd_pkg::*;
#(
  parameter int W = NIB_W,
  parameter int K = KIND_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_n,
  input  logic [W-1:0] lad_in,
  input  logic         busy_in,
  output logic         accept_o,
  output logic [K-1:0] kind_o,
  output logic         wr_o,
  output logic         abort_o,
  output logic         standby_o
);

  logic [W-1:0] start_q;
  logic         in_frame;
  logic         start_done;
  logic         legal_start;
  decode_t      dec;

  lpcd_frame_track #(.W(W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .lad_in     (lad_in),
    .start_q    (start_q),
    .in_frame   (in_frame),
    .start_done (start_done)
  );

  lpcd_classifier #(.W(W)) u_class (
    .start_q     (start_q),
    .lad_in      (lad_in),
    .start_done  (start_done),
    .dec         (dec),
    .legal_start (legal_start)
  );

  lpcd_out_stage #(.W(W), .K(K)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .in_frame  (in_frame),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .busy_in   (busy_in),
    .accept_o  (accept_o),
    .kind_o    (kind_o),
    .wr_o      (wr_o),
    .abort_o   (abort_o),
    .standby_o (standby_o)
  );

  // R5: an accept always follows a legal captured START code
  p_accept_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> $past(legal_start));

  // R8: a low strobe on the type edge never yields an accept next clock
  p_low_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !accept_o);

  // R6: accept comes after a low edge followed by a high edge
  p_accept_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> ($past(frame_n) && $past(in_frame)));

endmodule

// File: tb/test_lpc_cycle_decoder.sv
module test_lpc_cycle_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [3:0] lad = 4'hF;
  logic       busy = 1'b0;
  logic       accept, wr, abort_f, standby;
  logic [1:0] kind;

  int n_checks = 0;
  int n_errors = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  lpc_cycle_decoder i_lpc_cycle_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_in    (lad),
    .busy_in   (busy),
    .accept_o  (accept),
    .kind_o    (kind),
    .wr_o      (wr),
    .abort_o   (abort_f),
    .standby_o (standby)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int acc, input int k, input int d);
    chk(req, "accept", int'(accept), acc);
    chk(req, "kind", int'(kind), k);
    chk(req, "wr", int'(wr), d);
  endtask

  // drive on the falling edge, then sample shortly after the rising edge
  task automatic step(input logic f, input logic [3:0] l);
    @(negedge clk);
    frame_n = f;
    lad = l;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; frame_n = 1'b0; lad = 4'hD; busy = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk_out("R1", 0, 0, 0);
    chk("R1", "abort", int'(abort_f), 0);
    chk("R1", "standby", int'(standby), 0);
    @(negedge clk);
    rst_n = 1'b1; frame_n = 1'b1; lad = 4'hF; busy = 1'b0;
    step(1'b1, 4'hF);
    chk("R10", "standby idle", int'(standby), 1);
    chk_out("R11", 0, 0, 0);
  endtask

  task automatic t_firmware();
    step(1'b0, 4'b1101);
    chk("R6", "accept during low", int'(accept), 0);
    chk("R10", "standby during low", int'(standby), 0);
    step(1'b1, 4'b1010);
    chk_out("R4", 1, 2, 0);
    chk("R10", "standby on decode", int'(standby), 0);
    step(1'b1, 4'hF);
    chk_out("R6", 0, 0, 0);
    step(1'b0, 4'b1110);
    step(1'b1, 4'b0000);
    chk_out("R4", 1, 3, 1);
    step(1'b1, 4'hF);
    chk_out("R11", 0, 0, 0);
  endtask

  task automatic t_gen_mem();
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0100);
    chk_out("R3", 1, 1, 0);
    step(1'b1, 4'hF);
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0110);
    chk_out("R3", 1, 1, 1);
    step(1'b1, 4'hF);
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0111);
    chk_out("R3", 1, 1, 1);
    step(1'b1, 4'hF);
  endtask

  task automatic t_multi_low();
    step(1'b0, 4'b0101);
    step(1'b0, 4'b1101);
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0110);
    chk_out("R2", 1, 1, 1);
    step(1'b1, 4'hF);
    step(1'b0, 4'b0000);
    step(1'b0, 4'b0000);
    step(1'b0, 4'b1110);
    step(1'b1, 4'b0000);
    chk_out("R2", 1, 3, 1);
    step(1'b1, 4'hF);
  endtask

  task automatic t_illegal();
    logic [3:0] codes [4] = '{4'b0001, 4'b0101, 4'b1111, 4'b1100};
    for (int i = 0; i < 4; i++) begin
      step(1'b0, codes[i]);
      step(1'b1, 4'b0100);
      chk_out("R5", 0, 0, 0);
      step(1'b1, 4'hF);
    end
  endtask

  task automatic t_bad_type();
    logic [3:0] types [3] = '{4'b0000, 4'b1000, 4'b1100};
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 4'b0000);
      step(1'b1, types[i]);
      chk_out("R7", 0, 0, 0);
      step(1'b1, 4'hF);
    end
  endtask

  task automatic t_abort_type();
    step(1'b0, 4'b0000);
    step(1'b0, 4'b0101);
    chk("R8", "accept on low type edge", int'(accept), 0);
    step(1'b1, 4'b0100);
    chk_out("R8", 0, 0, 0);
    step(1'b1, 4'hF);
    step(1'b0, 4'b0000);
    step(1'b0, 4'b1101);
    step(1'b1, 4'b0100);
    chk_out("R8", 1, 2, 0);
    step(1'b1, 4'hF);
  endtask

  task automatic t_abort_standby();
    busy = 1'b1;
    step(1'b1, 4'hF);
    chk("R10", "standby while busy", int'(standby), 0);
    chk("R9", "abort while idle", int'(abort_f), 0);
    step(1'b0, 4'hF);
    chk("R9", "abort on low while busy", int'(abort_f), 1);
    step(1'b1, 4'hF);
    chk("R9", "abort single clock", int'(abort_f), 0);
    chk_out("R5", 0, 0, 0);
    busy = 1'b0;
    step(1'b0, 4'hF);
    chk("R9", "no abort when not busy", int'(abort_f), 0);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R10", "standby back", int'(standby), 1);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_firmware();
    t_gen_mem();
    t_multi_low();
    t_illegal();
    t_bad_type();
    t_abort_type();
    t_abort_standby();
    report();
    $finish;
  end

endmodule